// File: doc/BRIEF.md
# Serial EEPROM Page-Write Slave

This block is the write side of a two-wire serial memory slave. It watches SCL and SDA through a fast system clock and recognises start and stop conditions. It then takes in a device byte, a one-byte word address and any number of data bytes. Each accepted byte is acknowledged by pulling SDA low through an open-drain output enable. Data bytes collect in a page buffer. The page part of the word address stays fixed, while the byte offset inside the page advances and wraps.

A stop that lands on a byte boundary after at least one acknowledged data byte copies the loaded bytes into a 256-byte register array. The block then stays busy for a parameterised number of clock cycles, which models the slow nonvolatile write. While busy it refuses its own device byte, so a host can poll for completion by repeating start plus device byte until an acknowledge returns. A combinational inspection port shows any array location. Reads over the bus are not part of this block.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset every array location reads 8'hFF, `sda_oe` is 0 and `busy` is 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. When the block is not busy, a device byte whose bits 7:4 equal 4'b1010 is acknowledged. A device byte with any other upper nibble gets no acknowledge, and the transfer that follows stores nothing.
- R3: During a write, the word-address byte and every data byte are acknowledged. The block drives `sda_oe` high through the ninth SCL clock of the byte.
- R4: Bits 7:4 of the word address select the 16-byte page and bits 3:0 the starting offset. Each data byte goes to the current offset, and the offset then advances by one. After offset 15 it wraps to 0 of the same page. The page never changes.
- R5: When more than 16 data bytes are loaded, each later byte replaces the earlier byte at the same offset.
- R6: A commit writes only the offsets that received data. Other offsets of the page and all other pages keep their contents.
- R7: A stop on a byte boundary after at least one fully acknowledged data byte updates the array and raises `busy` for WRITE_CYCLES clock cycles.
- R8: A stop in the middle of a data byte, or before the first data byte has been acknowledged, writes nothing and does not raise `busy`.
- R9: While `busy` is high, a matching device byte with R/W bit 0 is not acknowledged. Once `busy` has dropped, the same sequence is acknowledged.
- R10: A matching device byte with bit 0 set (read) is acknowledged when the block is idle. Bytes after it get no acknowledge, and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy | output | 1 | Timed commit cycle in progress |
| peek_addr | input | 8 | Array location to inspect |
| peek_data | output | 8 | Contents of the inspected location |

## Verification
Some rules are checked by assertions on every cycle. The acknowledge enable only changes while the synchronised SCL is low. A stop always releases SDA. The page bits stay frozen and the offset steps by one modulo 16 through a data phase. No acknowledge is given to a device byte while busy. A commit never starts during busy, and the busy counter stays in range. The bench scenarios cover what needs complete bus transactions. These are wrap-around placement, overwrite past 16 bytes, untouched neighbours, aborted stops, polling before and after the cycle, read-addressed transfers and foreign device codes. All are judged through the inspection port and the acknowledge bits seen on the wire.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int WORD_AW = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } ld_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b);
        return b[7:4] == DEV_TYPE;
    endfunction

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler
    import eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev_o
);
    logic [2:0] scl_sh, sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= 3'b111;
            sda_sh <= 3'b111;
        end else begin
            scl_sh <= {scl_sh[1:0], scl_in};
            sda_sh <= {sda_sh[1:0], sda_in};
        end
    end

    always_comb begin
        ev_o.scl   = scl_sh[1];
        ev_o.sda   = sda_sh[1];
        ev_o.rise  = scl_sh[1] & ~scl_sh[2];
        ev_o.fall  = ~scl_sh[1] & scl_sh[2];
        ev_o.start = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
        ev_o.stop  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
    end
endmodule

// File: rtl/page_loader.sv
module page_loader
    import eeprom_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int PG_W  = WORD_AW - OFF_W
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_ev_t         ev_i,
    input  logic            busy_i,
    output logic            sda_oe_o,
    output logic            go_o,
    output logic [PG_W-1:0] page_o,
    output logic [7:0]      pg_buf_o [PAGE_BYTES],
    output logic [PAGE_BYTES-1:0] valid_o
);
    ld_state_t             st;
    logic [3:0]            bit_cnt;
    logic [7:0]            shreg;
    logic [PG_W-1:0]       page_q;
    logic [OFF_W-1:0]      off_q;
    logic [PAGE_BYTES-1:0] valid_q;
    logic [7:0]            pg_buf [PAGE_BYTES];
    logic                  oe_q, go_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            page_q  <= '0;
            off_q   <= '0;
            valid_q <= '0;
            oe_q    <= 1'b0;
            go_q    <= 1'b0;
            for (int i = 0; i < PAGE_BYTES; i++) pg_buf[i] <= '0;
        end else begin
            go_q <= 1'b0;
            if (ev_i.stop) begin
                if (st == ST_DATA && bit_cnt <= 4'd1 && |valid_q) go_q <= 1'b1;
                st   <= ST_IDLE;
                oe_q <= 1'b0;
            end else if (ev_i.start) begin
                st      <= ST_DEV;
                bit_cnt <= '0;
                valid_q <= '0;
                oe_q    <= 1'b0;
            end else begin
                case (st)
                    ST_DEV, ST_WADR, ST_DATA: begin
                        if (ev_i.rise) begin
                            shreg   <= {shreg[6:0], ev_i.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev_i.fall && bit_cnt == 4'd8) begin
                            if (st == ST_DEV) begin
                                if (dev_match(shreg) && !busy_i) begin
                                    oe_q <= 1'b1;
                                    st   <= ST_DEV_ACK;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else if (st == ST_WADR) begin
                                page_q <= shreg[WORD_AW-1:OFF_W];
                                off_q  <= shreg[OFF_W-1:0];
                                oe_q   <= 1'b1;
                                st     <= ST_WADR_ACK;
                            end else begin
                                oe_q <= 1'b1;
                                st   <= ST_DATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_WADR_ACK, ST_DATA_ACK: begin
                        if (ev_i.fall) begin
                            oe_q    <= 1'b0;
                            bit_cnt <= '0;
                            if (st == ST_DEV_ACK) begin
                                st <= shreg[0] ? ST_SKIP : ST_WADR;
                            end else if (st == ST_WADR_ACK) begin
                                st <= ST_DATA;
                            end else begin
                                pg_buf[off_q]  <= shreg;
                                valid_q[off_q] <= 1'b1;
                                off_q          <= off_q + OFF_W'(1);
                                st             <= ST_DATA;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = oe_q;
    assign go_o     = go_q;
    assign page_o   = page_q;
    assign pg_buf_o = pg_buf;
    assign valid_o  = valid_q;

    // R3: the acknowledge drive only switches while SCL is low
    p_ack_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $changed(oe_q) |-> !ev_i.scl);
    // R2: a stop leaves SDA released
    p_stop_release_r2: assert property (@(posedge clk) disable iff (rst)
        $past(ev_i.stop) |-> !oe_q);
    // R9: no device acknowledge while the commit cycle runs
    p_poll_nack_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(oe_q) && st == ST_DEV_ACK) |-> !busy_i);
    // R4: page fixed during the data phase
    p_page_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_DATA || st == ST_DATA_ACK) &&
         ($past(st) == ST_DATA || $past(st) == ST_DATA_ACK)) |-> $stable(page_q));
    // R4: offset advances by one (mod page) per accepted byte
    p_off_step_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_DATA_ACK && st == ST_DATA) |->
        off_q == OFF_W'($past(off_q) + OFF_W'(1)));
endmodule

// File: rtl/commit_store.sv
module commit_store
    import eeprom_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 500000,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int PG_W  = WORD_AW - OFF_W,
    localparam int DEPTH = 1 << WORD_AW,
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go_i,
    input  logic [PG_W-1:0]       page_i,
    input  logic [7:0]            pg_buf_i [PAGE_BYTES],
    input  logic [PAGE_BYTES-1:0] valid_i,
    input  logic [WORD_AW-1:0]    peek_addr_i,
    output logic [7:0]            peek_data_o,
    output logic                  busy_o
);
    logic [7:0]       mem [DEPTH];
    logic             busy_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
            busy_q <= 1'b0;
            cnt    <= '0;
        end else if (go_i) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (valid_i[i]) mem[{page_i, OFF_W'(i)}] <= pg_buf_i[i];
            busy_q <= 1'b1;
            cnt    <= CNT_W'(WRITE_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt == '0) busy_q <= 1'b0;
            else           cnt    <= cnt - CNT_W'(1);
        end
    end

    assign peek_data_o = mem[peek_addr_i];
    assign busy_o      = busy_q;

    // R7: a commit is only launched from the idle state and always starts busy
    p_go_idle_r7: assert property (@(posedge clk) disable iff (rst)
        go_i |-> !busy_q);
    p_go_busy_r7: assert property (@(posedge clk) disable iff (rst)
        go_i |=> busy_q);
    // R7: counter stays within the configured window
    p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> cnt < CNT_W'(WRITE_CYCLES));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 500000,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int PG_W  = WORD_AW - OFF_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       busy,
    input  logic [7:0] peek_addr,
    output logic [7:0] peek_data
);
    bus_ev_t               ev;
    logic                  go;
    logic [PG_W-1:0]       page;
    logic [7:0]            pg_buf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;

    bus_sampler u_smp (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev_o(ev)
    );

    page_loader #(.PAGE_BYTES(PAGE_BYTES)) u_ld (
        .clk(clk), .rst(rst), .ev_i(ev), .busy_i(busy),
        .sda_oe_o(sda_oe), .go_o(go), .page_o(page),
        .pg_buf_o(pg_buf), .valid_o(valid)
    );

    commit_store #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_st (
        .clk(clk), .rst(rst), .go_i(go), .page_i(page),
        .pg_buf_i(pg_buf), .valid_i(valid), .peek_addr_i(peek_addr),
        .peek_data_o(peek_data), .busy_o(busy)
    );
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int WCYC       = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_oe, busy;
    logic [7:0] peek_addr = 8'h00;
    logic [7:0] peek_data;
    logic       sda_line;
    int         checks = 0;
    int         errors = 0;

    assign sda_line = ~(m_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_page_writer #(.PAGE_BYTES(16), .WRITE_CYCLES(WCYC)) u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .busy(busy), .peek_addr(peek_addr), .peek_data(peek_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        peek_addr = a;
        #1;
        d = peek_data;
    endtask

    task automatic chk_mem(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        peek(a, d);
        chk(req, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq(); scl = 1'b1; wq();
        m_low = 1'b1; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(); scl = 1'b1; wq();
        m_low = 1'b0; wq(); wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; wq();
            scl = 1'b1; wq(); wq();
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_low = 1'b0; wq();
        scl = 1'b1; wq();
        ack = ~sda_line;
        wq();
        scl = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 4 * WCYC && busy; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 sda_oe", {31'h0, sda_oe}, 32'h0);
        chk("R1 busy", {31'h0, busy}, 32'h0);
        for (int a = 0; a < 256; a += 37) begin
            peek(8'(a), d);
            chk("R1 array", {24'h0, d}, 32'hFF);
        end
    endtask

    task automatic t_wrap();
        logic ack;
        logic all_ack = 1'b1;
        bus_start();
        send_byte(8'hA0, ack);
        chk("R2 device ack", {31'h0, ack}, 32'h1);
        send_byte(8'h3A, ack);
        chk("R3 address ack", {31'h0, ack}, 32'h1);
        for (int i = 0; i < 12; i++) begin
            send_byte(8'h40 + 8'(i), ack);
            all_ack &= ack;
        end
        chk("R3 data acks", {31'h0, all_ack}, 32'h1);
        bus_stop();
        chk("R7 busy after stop", {31'h0, busy}, 32'h1);
        wait_idle();
        chk("R7 busy drops", {31'h0, busy}, 32'h0);
        for (int i = 0; i < 6; i++) chk_mem("R4 first part", 8'h3A + 8'(i), 8'h40 + 8'(i));
        for (int i = 0; i < 6; i++) chk_mem("R4 wrapped part", 8'h30 + 8'(i), 8'h46 + 8'(i));
        for (int i = 6; i < 10; i++) chk_mem("R6 untouched offset", 8'h30 + 8'(i), 8'hFF);
        chk_mem("R6 page below", 8'h2F, 8'hFF);
        chk_mem("R6 page above", 8'h40, 8'hFF);
    endtask

    task automatic t_poll();
        logic ack;
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h12, ack);
        send_byte(8'hC3, ack);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ack);
        chk("R9 nack while busy", {31'h0, ack}, 32'h0);
        bus_stop();
        chk("R9 still busy", {31'h0, busy}, 32'h1);
        wait_idle();
        chk_mem("R7 single byte", 8'h12, 8'hC3);
        bus_start();
        send_byte(8'hA0, ack);
        chk("R9 ack after cycle", {31'h0, ack}, 32'h1);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R8 stop after device byte", {31'h0, busy}, 32'h0);
    endtask

    task automatic t_overflow();
        logic ack;
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h50, ack);
        for (int i = 0; i < 18; i++) send_byte(8'h80 + 8'(i), ack);
        bus_stop();
        wait_idle();
        chk_mem("R5 offset0 overwritten", 8'h50, 8'h90);
        chk_mem("R5 offset1 overwritten", 8'h51, 8'h91);
        chk_mem("R5 offset2 kept", 8'h52, 8'h82);
        chk_mem("R5 offset15", 8'h5F, 8'h8F);
    endtask

    task automatic t_abort();
        logic ack;
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h60, ack);
        send_byte(8'h11, ack);
        send_bits(8'h22, 4);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R8 mid-byte stop no busy", {31'h0, busy}, 32'h0);
        chk_mem("R8 mid-byte stop no write", 8'h60, 8'hFF);
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h61, ack);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R8 stop after address no busy", {31'h0, busy}, 32'h0);
    endtask

    task automatic t_foreign();
        logic ack;
        bus_start();
        send_byte(8'hB0, ack);
        chk("R2 foreign code nack", {31'h0, ack}, 32'h0);
        send_byte(8'h70, ack);
        send_byte(8'h55, ack);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R2 foreign no busy", {31'h0, busy}, 32'h0);
        chk_mem("R2 foreign no write", 8'h70, 8'hFF);
    endtask

    task automatic t_read_addr();
        logic ack;
        bus_start();
        send_byte(8'hA1, ack);
        chk("R10 read address ack", {31'h0, ack}, 32'h1);
        send_byte(8'h08, ack);
        chk("R10 following byte nack", {31'h0, ack}, 32'h0);
        send_byte(8'h77, ack);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R10 no busy", {31'h0, busy}, 32'h0);
        chk_mem("R10 no write", 8'h08, 8'hFF);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_wrap();
        t_poll();
        t_overflow();
        t_abort();
        t_foreign();
        t_read_addr();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule